// File: doc/BRIEF.md
# Bit-group Reverse, OR-combine and Interleave Unit

This block permutes the bits of a 64-bit word through a small set of butterfly stages. Each bit of a control value switches one stage on. The stage either swaps neighbouring bit groups of size 1, 2, 4, 8, 16 or 32, or ORs each group with its swapped partner. A second family of masked exchange stages interleaves the two halves of a field (shuffle) or separates them again (unshuffle).

A word-mode flag narrows the operation to the low 32 bits. The 32-bit result is then sign-extended to the full width. The caller supplies the operand, the control amount, the operation code and the mode flag with a valid strobe. The permuted word comes back from an output register one clock later.

Top module: `bit_permuter`

## Requirements
- R1: While `rst` is high, and in the cycle after it, `out_valid` is 0 and `result` is all zeros.
- R2: `out_valid` equals `in_valid` of the previous cycle, and `result` holds its value in any cycle after one where `in_valid` was low.
- R3: With `op` = 0 (reverse), bit k of `ctrl` exchanges every adjacent pair of 2^k-bit groups. The active stages compose, so `ctrl` = 63 reverses the word and `ctrl` = 56 reverses its bytes. A zero control value passes the operand through unchanged for every `op`.
- R4: With `op` = 1 (OR-combine), each active stage ORs the group-swapped word into the running value. The result therefore always covers every set bit of the operand.
- R5: With `op` = 2 (shuffle), control bits 4 down to 0 enable exchange stages of size 16, 8, 4, 2 and 1, applied in that order. A stage of size N keeps the bits of each 4N-bit block that lie outside its middle half. It moves the quarter at offset N up by N and the quarter at offset 2N down by N. With `ctrl` = 31, the low half of the word lands on even bit positions.
- R6: With `op` = 3 (unshuffle), the same stages run in the order 1, 2, 4, 8, 16. Unshuffle undoes shuffle for any operand and the same control value.
- R7: In 64-bit mode, shuffle and unshuffle ignore `ctrl` bit 5.
- R8: With `word_mode` = 1, only bits 31:0 of the operand are used. The 32-bit result is sign-extended from bit 31, and bits 63:32 of the operand have no effect.
- R9: In word mode, reverse and OR-combine use `ctrl[4:0]` only, and shuffle and unshuffle use `ctrl[3:0]` only (stages 8, 4, 2, 1).
- R10: Reverse, shuffle and unshuffle in 64-bit mode preserve the number of set bits. Reverse applied twice with the same control value returns the operand.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation request strobe |
| op | input | 2 | 0 reverse, 1 OR-combine, 2 shuffle, 3 unshuffle |
| word_mode | input | 1 | 1 selects the 32-bit operation with sign extension |
| ctrl | input | 6 | Stage enable / control amount |
| operand | input | 64 | Word to permute |
| out_valid | output | 1 | Result register holds a new value |
| result | output | 64 | Permuted word |

## Verification
The bench builds the block with its default width of 64, so the half-width network is 32 bits wide and `ctrl` is 6 bits. This width makes every stage size from 1 to 32 reachable. It also leaves one spare control bit for each of the ignored-bit cases in 64-bit and word mode, and it puts a sign boundary at bit 31. Hand-computed vectors pin down the stage masks and the stage ordering. Pseudo-random operands check the round trips and the insensitivity to the upper half in word mode.

// File: rtl/bperm_pkg.sv
package bperm_pkg;
  typedef enum logic [1:0] {
    BP_REV   = 2'd0,
    BP_ORC   = 2'd1,
    BP_ZIP   = 2'd2,
    BP_UNZIP = 2'd3
  } bp_op_e;
endpackage

// File: rtl/bperm_butterfly.sv
// Swap / OR-combine network of log2(DW) stages.
module bperm_butterfly #(
  parameter int DW = 64,
  localparam int LG = $clog2(DW)
) (
  input  logic [DW-1:0] din,
  input  logic [LG-1:0] sel,
  input  logic          or_mode,
  output logic [DW-1:0] dout
);
  // lower group of each pair for a stage of size 2^k
  function automatic logic [DW-1:0] lo_groups(input int k);
    logic [DW-1:0] m;
    for (int i = 0; i < DW; i++) m[i] = ((i >> k) & 1) == 0;
    return m;
  endfunction

  always_comb begin
    logic [DW-1:0] acc;
    logic [DW-1:0] swp;
    acc = din;
    for (int k = 0; k < LG; k++) begin
      swp = ((acc & lo_groups(k)) << (1 << k)) |
            ((acc & ~lo_groups(k)) >> (1 << k));
      if (sel[k]) acc = or_mode ? (acc | swp) : swp;
    end
    dout = acc;
  end
endmodule

// File: rtl/bperm_shuffle.sv
// Masked exchange stages; order descending for zip, ascending for unzip.
module bperm_shuffle #(
  parameter int DW = 64,
  localparam int LG = $clog2(DW),
  localparam int NS = LG - 1
) (
  input  logic [DW-1:0] din,
  input  logic [NS-1:0] sel,
  input  logic          unzip,
  output logic [DW-1:0] dout
);
  // quarter at offset 2N inside each 4N block (receives upward move)
  function automatic logic [DW-1:0] up_mask(input int k);
    logic [DW-1:0] m;
    for (int i = 0; i < DW; i++)
      m[i] = (((i >> (k + 1)) & 1) == 1) && (((i >> k) & 1) == 0);
    return m;
  endfunction

  // quarter at offset N inside each 4N block (receives downward move)
  function automatic logic [DW-1:0] dn_mask(input int k);
    logic [DW-1:0] m;
    for (int i = 0; i < DW; i++)
      m[i] = (((i >> (k + 1)) & 1) == 0) && (((i >> k) & 1) == 1);
    return m;
  endfunction

  function automatic logic [DW-1:0] xstage(input logic [DW-1:0] x, input int k);
    return (x & ~(up_mask(k) | dn_mask(k))) |
           ((x << (1 << k)) & up_mask(k)) |
           ((x >> (1 << k)) & dn_mask(k));
  endfunction

  logic [DW-1:0] zip_q, unzip_q;

  always_comb begin
    logic [DW-1:0] acc;
    acc = din;
    for (int k = NS - 1; k >= 0; k--)
      if (sel[k]) acc = xstage(acc, k);
    zip_q = acc;
  end

  always_comb begin
    logic [DW-1:0] acc;
    acc = din;
    for (int k = 0; k < NS; k++)
      if (sel[k]) acc = xstage(acc, k);
    unzip_q = acc;
  end

  assign dout = unzip ? unzip_q : zip_q;
endmodule

// File: rtl/bit_permuter.sv
module bit_permuter #(
  parameter int W = 64,
  localparam int LG  = $clog2(W),
  localparam int HW  = W / 2,
  localparam int HLG = LG - 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic [1:0]    op,
  input  logic          word_mode,
  input  logic [LG-1:0] ctrl,
  input  logic [W-1:0]  operand,
  output logic          out_valid,
  output logic [W-1:0]  result
);
  import bperm_pkg::*;

  bp_op_e op_e;
  assign op_e = bp_op_e'(op);

  logic is_shuf;
  assign is_shuf = (op_e == BP_ZIP) || (op_e == BP_UNZIP);

  logic [W-1:0]  bf_full, sh_full, full_val;
  logic [HW-1:0] bf_half, sh_half, half_val;
  logic [W-1:0]  next_val;

  bperm_butterfly #(.DW(W)) u_bf_full (
    .din(operand), .sel(ctrl), .or_mode(op_e == BP_ORC), .dout(bf_full));

  bperm_butterfly #(.DW(HW)) u_bf_half (
    .din(operand[HW-1:0]), .sel(ctrl[HLG-1:0]), .or_mode(op_e == BP_ORC),
    .dout(bf_half));

  bperm_shuffle #(.DW(W)) u_sh_full (
    .din(operand), .sel(ctrl[LG-2:0]), .unzip(op_e == BP_UNZIP),
    .dout(sh_full));

  bperm_shuffle #(.DW(HW)) u_sh_half (
    .din(operand[HW-1:0]), .sel(ctrl[HLG-2:0]), .unzip(op_e == BP_UNZIP),
    .dout(sh_half));

  assign full_val = is_shuf ? sh_full : bf_full;
  assign half_val = is_shuf ? sh_half : bf_half;
  assign next_val = word_mode ? {{HW{half_val[HW-1]}}, half_val} : full_val;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      result    <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) result <= next_val;
    end
  end

  // R2: output strobe follows the request strobe by one cycle
  p_valid_follow_r2: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  p_idle_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && $stable(result)));
  // R4: OR-combine never loses an operand bit
  p_orc_cover_r4: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op_e == BP_ORC && !word_mode) |=>
      ((result & $past(operand)) == $past(operand)));
  // R10: pure permutations keep the population count
  p_perm_ones_r10: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op_e != BP_ORC && !word_mode) |=>
      ($countones(result) == $countones($past(operand))));
  // R8: word-mode results are sign-extended from bit HW-1
  p_sext_r8: assert property (@(posedge clk) disable iff (rst)
    (in_valid && word_mode) |=>
      (result[W-1:HW] == {HW{result[HW-1]}}));
  // R3: an all-zero control value is a pass-through
  p_zero_ctrl_r3: assert property (@(posedge clk) disable iff (rst)
    (in_valid && ctrl == '0 && !word_mode) |=> (result == $past(operand)));
endmodule

// File: tb/bit_permuter_tb_top.sv
module bit_permuter_tb_top;
  localparam int W = 64;
  localparam int NV = 17;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic [1:0] op = 2'd0;
  logic word_mode = 1'b0;
  logic [5:0] ctrl = 6'd0;
  logic [W-1:0] operand = '0;
  logic out_valid;
  logic [W-1:0] result;

  int n_checks = 0;
  int n_fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  bit_permuter #(.W(W)) dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op(op),
    .word_mode(word_mode), .ctrl(ctrl), .operand(operand),
    .out_valid(out_valid), .result(result));

  // op: 0 rev, 1 orc, 2 shuffle, 3 unshuffle
  localparam logic [1:0] T_OP [NV] = '{
    2'd0, 2'd0, 2'd0,        // R3 full reverse, half swap, byte reverse
    2'd1, 2'd1,              // R4 byte OR-combine, full OR-combine
    2'd2, 2'd2, 2'd2, 2'd2,  // R5 full zip (two), single stages 1 and 16
    2'd3,                    // R6 full unzip
    2'd2,                    // R7 ctrl bit 5 ignored by zip
    2'd0, 2'd1,              // R8 word reverse, word OR-combine
    2'd0, 2'd2, 2'd2,        // R9 word ctrl masking
    2'd0                     // R3 zero control
  };
  localparam logic [5:0] T_CTRL [NV] = '{
    6'h3F, 6'h20, 6'h38, 6'h07, 6'h3F, 6'h1F, 6'h1F, 6'h01, 6'h10,
    6'h1F, 6'h3F, 6'h1F, 6'h1F, 6'h3F, 6'h1F, 6'h0F, 6'h00
  };
  localparam logic T_WM [NV] = '{
    1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0,
    1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0
  };
  localparam logic [W-1:0] T_A [NV] = '{
    64'h0000000000000001, 64'h0123456789ABCDEF, 64'h0123456789ABCDEF,
    64'h0000000000000100, 64'h0000000000000001, 64'h00000000FFFFFFFF,
    64'hFFFFFFFF00000000, 64'h0000000000000002, 64'h0000000000010000,
    64'h5555555555555555, 64'h00000000FFFFFFFF, 64'hFFFFFFFF00000001,
    64'h0000000000000001, 64'h0000000000000002, 64'h000000000000FFFF,
    64'h00000000FFFF0000, 64'h0123456789ABCDEF
  };
  localparam logic [W-1:0] T_EXP [NV] = '{
    64'h8000000000000000, 64'h89ABCDEF01234567, 64'hEFCDAB8967452301,
    64'h000000000000FF00, 64'hFFFFFFFFFFFFFFFF, 64'h5555555555555555,
    64'hAAAAAAAAAAAAAAAA, 64'h0000000000000004, 64'h0000000100000000,
    64'h00000000FFFFFFFF, 64'h5555555555555555, 64'hFFFFFFFF80000000,
    64'hFFFFFFFFFFFFFFFF, 64'h0000000040000000, 64'h0000000055555555,
    64'hFFFFFFFFAAAAAAAA, 64'h0123456789ABCDEF
  };
  localparam int T_REQ [NV] = '{3, 3, 3, 4, 4, 5, 5, 5, 5, 6, 7, 8, 8, 9, 9, 9, 3};

  task automatic check(input string tag, input logic [W-1:0] got,
                       input logic [W-1:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic apply(input logic [1:0] o, input logic [5:0] c,
                       input logic wm, input logic [W-1:0] a,
                       output logic [W-1:0] r);
    @(negedge clk);
    op = o; ctrl = c; word_mode = wm; operand = a; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    r = result;
  endtask

  function automatic logic [W-1:0] next_rand(input logic [W-1:0] s);
    logic [W-1:0] x;
    x = s;
    x = x ^ (x << 13);
    x = x ^ (x >> 7);
    x = x ^ (x << 17);
    return x;
  endfunction

  initial begin
    logic [W-1:0] r1, r2, held;
    logic [W-1:0] seed;
    string tag;
    seed = 64'h9E3779B97F4A7C15;

    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 out_valid in reset", {63'd0, out_valid}, 64'd0);
    check("R1 result in reset", result, 64'd0);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 out_valid after reset", {63'd0, out_valid}, 64'd0);

    // vector table
    for (int i = 0; i < NV; i++) begin
      apply(T_OP[i], T_CTRL[i], T_WM[i], T_A[i], r1);
      tag = $sformatf("R%0d vector %0d", T_REQ[i], i);
      check(tag, r1, T_EXP[i]);
    end

    // R2: valid strobe and hold after an idle cycle
    apply(2'd0, 6'h3F, 1'b0, 64'h1, held);
    check("R2 out_valid with result", {63'd0, out_valid}, 64'd1);
    @(negedge clk);
    check("R2 out_valid drops", {63'd0, out_valid}, 64'd0);
    operand = 64'hFFFF; ctrl = 6'h01;
    @(negedge clk);
    check("R2 result held while idle", result, held);

    // randomized round trips
    for (int n = 0; n < 24; n++) begin
      logic [5:0] c;
      seed = next_rand(seed);
      c = seed[63:58];
      // R6 shuffle then unshuffle
      apply(2'd2, c, 1'b0, seed, r1);
      apply(2'd3, c, 1'b0, r1, r2);
      check("R6 unshuffle inverts shuffle", r2, seed);
      // R10 reverse twice
      apply(2'd0, c, 1'b0, seed, r1);
      apply(2'd0, c, 1'b0, r1, r2);
      check("R10 double reverse identity", r2, seed);
      // R8 upper operand half ignored in word mode
      apply(n[1:0], c, 1'b1, seed, r1);
      apply(n[1:0], c, 1'b1, {~seed[63:32], seed[31:0]}, r2);
      check("R8 upper half ignored", r2, r1);
    end

    // R1 reset clears a loaded result
    apply(2'd1, 6'h3F, 1'b0, 64'h1, r1);
    rst = 1'b1;
    @(negedge clk);
    check("R1 result cleared by reset", result, 64'd0);
    rst = 1'b0;

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end

  initial begin
    #(8 * 50000);
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
    end
  end
endmodule